// File: doc/BRIEF.md
# Controllerless TFT Frame Scanner

This block scans a frame buffer out to a TFT panel that has no controller of its own. It produces the frame sync, the line sync, a per-pixel strobe, an active-low panel enable and a 16-bit RGB565 pixel bus. Pixels are fetched from a synchronous frame-buffer read port, addressed by word, with one clock of read latency. Every porch slot carries all-zero dummy data.

A frame is launched by an external frame-rate tick. If a tick arrives while a frame is running, it is held and the next frame follows the current one without a gap. Two frame-buffer base addresses are parameters. A select input picks one of them, or a slide-show mode alternates between them after a fixed number of frames. The buffer choice is latched only when a frame starts, so one frame never mixes two images.

Each line runs through four segments in this order: sync low, leading dummy, active pixels, trailing dummy. Each frame runs through the same four segments, counted in lines. All segment lengths are parameters. The defaults give a 408-clock line and a 262-line frame around a 320×240 image.

Top module: `tft_frame_scanner`

## Requirements
- R1: Out of reset, and whenever no frame is running, `lcd_en_n`, `lcd_hsync_n` and `lcd_vsync_n` are high, `lcd_dclk` is low and `lcd_rgb` is zero.
- R2: A frame starts only on `frame_tick`. A tick that arrives during a frame is held, and the next frame's first strobe follows the current frame's last strobe in the next clock. Further ticks inside the same frame collapse into that one pending start. No frame runs without a tick.
- R3: `lcd_en_n` falls one clock before a frame's first strobe and stays low through the frame. It rises in the clock after the last strobe, unless another frame follows.
- R4: A frame carries exactly H_TOT×V_TOT strobes, one pixel per clock. In each line of H_TOT strobes, `lcd_hsync_n` is low for the first H_SYNC strobes. Those are followed by H_PRE dummy, H_ACT active and H_POST dummy strobes, with hsync high.
- R5: `lcd_vsync_n` is low during the first V_SYNC lines of the frame. It is high for the V_PRE dummy, V_ACT active and V_POST dummy lines that follow.
- R6: Every strobe outside the active window carries `lcd_rgb` = 0, whatever the frame-buffer port returns.
- R7: For an active pixel in active line y and column x, `fb_rd_addr` = base + y×H_ACT + x. `fb_rd_en` is high in the clock before that pixel's strobe. The word read back appears unchanged on `lcd_rgb` during the strobe, with red in bits 15:11, green in 10:5 and blue in 4:0.
- R8: With `slide_en` low, `buf_sel` (0 selects BASE0, 1 selects BASE1) is sampled only when a frame starts. A change during a frame has no effect on that frame.
- R9: With `slide_en` high, `buf_sel` is ignored. Each buffer is shown for SLIDE_FRAMES consecutive frames, then the scan swaps to the other one at a frame boundary. Out of reset the first buffer is BASE0.
- R10: A synchronous low on `rst_n` in the middle of a frame stops the frame and returns the block to the R1 state. It also drops any pending tick and resets the buffer choice to BASE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | Frame-rate pulse that requests a frame |
| slide_en | input | 1 | 1: alternate buffers every SLIDE_FRAMES frames |
| buf_sel | input | 1 | Manual buffer choice, 0 = BASE0, 1 = BASE1 |
| fb_rd_en | output | 1 | Frame-buffer read request |
| fb_rd_addr | output | AW | Frame-buffer word address |
| fb_rd_data | input | 16 | Read data, valid one clock after the request |
| lcd_en_n | output | 1 | Panel enable, active low |
| lcd_vsync_n | output | 1 | Frame sync, active low |
| lcd_hsync_n | output | 1 | Line sync, active low |
| lcd_dclk | output | 1 | Pixel strobe, high for each transferred pixel |
| lcd_rgb | output | 16 | RGB565 pixel data |

## Verification
The bench shrinks the geometry so that whole frames pass in a few dozen clocks. It uses 2+1+4+1 clocks per line and 1+1+3+1 lines per frame, with BASE1 = 100 and SLIDE_FRAMES = 2. Every sync segment and porch therefore gets exercised at least once per frame. Back-to-back frames with collapsed ticks, a manual buffer change in mid-frame, and a full slide-show rotation (BASE0, BASE0, BASE1, BASE1, BASE0) all fit in a short run. The frame-buffer model returns a nonzero word for every read and junk when not read, so any leak of read data into a porch becomes visible.

// File: rtl/tft_frame_scanner.sv
module tft_frame_scanner #(
  parameter int H_SYNC       = 20,
  parameter int H_PRE        = 48,
  parameter int H_ACT        = 320,
  parameter int H_POST       = 20,
  parameter int V_SYNC       = 2,
  parameter int V_PRE        = 16,
  parameter int V_ACT        = 240,
  parameter int V_POST       = 4,
  parameter int AW           = 18,
  parameter int BASE0        = 0,
  parameter int BASE1        = 76800,
  parameter int SLIDE_FRAMES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          slide_en,
  input  logic          buf_sel,
  output logic          fb_rd_en,
  output logic [AW-1:0] fb_rd_addr,
  input  logic [15:0]   fb_rd_data,
  output logic          lcd_en_n,
  output logic          lcd_vsync_n,
  output logic          lcd_hsync_n,
  output logic          lcd_dclk,
  output logic [15:0]   lcd_rgb
);

  localparam int H_TOT = H_SYNC + H_PRE + H_ACT + H_POST;
  localparam int V_TOT = V_SYNC + V_PRE + V_ACT + V_POST;
  localparam int HW    = $clog2(H_TOT + 1);
  localparam int VW    = $clog2(V_TOT + 1);
  localparam int FW    = $clog2(SLIDE_FRAMES + 1);

  localparam logic [HW-1:0] HS_END = HW'(H_SYNC);
  localparam logic [HW-1:0] HA_BEG = HW'(H_SYNC + H_PRE);
  localparam logic [HW-1:0] HA_END = HW'(H_SYNC + H_PRE + H_ACT);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] VS_END = VW'(V_SYNC);
  localparam logic [VW-1:0] VA_BEG = VW'(V_SYNC + V_PRE);
  localparam logic [VW-1:0] VA_END = VW'(V_SYNC + V_PRE + V_ACT);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic [FW-1:0] fcnt, nxt_fcnt;
  logic [AW-1:0] addr_q;
  logic busy, pend, cur_buf, nxt_buf;
  logic act_q, stb_q, hs_q, vs_q, en_q;

  wire last  = busy && hc == H_LAST && vc == V_LAST;
  wire go    = (frame_tick || pend) && (!busy || last);
  wire h_act = hc >= HA_BEG && hc < HA_END;
  wire v_act = vc >= VA_BEG && vc < VA_END;

  assign fb_rd_en    = busy && h_act && v_act;
  assign fb_rd_addr  = addr_q;
  assign lcd_en_n    = !en_q;
  assign lcd_hsync_n = hs_q;
  assign lcd_vsync_n = vs_q;
  assign lcd_dclk    = stb_q;
  assign lcd_rgb     = act_q ? fb_rd_data : 16'h0000;

  always_comb begin
    if (!slide_en) begin
      nxt_buf  = buf_sel;
      nxt_fcnt = FW'(1);
    end else if (fcnt >= FW'(SLIDE_FRAMES)) begin
      nxt_buf  = !cur_buf;
      nxt_fcnt = FW'(1);
    end else begin
      nxt_buf  = cur_buf;
      nxt_fcnt = fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pend    <= 1'b0;
      hc      <= '0;
      vc      <= '0;
      cur_buf <= 1'b0;
      fcnt    <= '0;
      addr_q  <= '0;
      act_q   <= 1'b0;
      stb_q   <= 1'b0;
      hs_q    <= 1'b1;
      vs_q    <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      pend  <= go ? 1'b0 : (pend || frame_tick);
      en_q  <= go || busy;
      stb_q <= busy;
      hs_q  <= !(busy && hc < HS_END);
      vs_q  <= !(busy && vc < VS_END);
      act_q <= fb_rd_en;
      if (go) begin
        busy    <= 1'b1;
        hc      <= '0;
        vc      <= '0;
        cur_buf <= nxt_buf;
        fcnt    <= nxt_fcnt;
        addr_q  <= nxt_buf ? AW'(BASE1) : AW'(BASE0);
      end else if (busy) begin
        if (fb_rd_en) addr_q <= addr_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          hc   <= '0;
          vc   <= '0;
        end else if (hc == H_LAST) begin
          hc <= '0;
          vc <= vc + 1'b1;
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en_n |-> (lcd_hsync_n && lcd_vsync_n && !lcd_dclk && lcd_rgb == 16'h0000));

  a_r3_enable_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_dclk) |-> $past(!lcd_en_n));

  a_r6_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_hsync_n || !lcd_vsync_n) |-> lcd_rgb == 16'h0000);

  a_r7_read_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |=> lcd_dclk);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd_en && $past(fb_rd_en)) |-> fb_rd_addr == $past(fb_rd_addr) + AW'(1));

  a_r8_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> $stable(cur_buf));

endmodule

// File: tb/test_tft_frame_scanner.sv
module test_tft_frame_scanner;
  localparam int HS = 2, HP = 1, HA = 4, HQ = 1;
  localparam int VS = 1, VP = 1, VA = 3, VQ = 1;
  localparam int HT = HS + HP + HA + HQ;
  localparam int VT = VS + VP + VA + VQ;
  localparam int AW = 10;
  localparam int B1 = 100;

  logic clk = 0, rst_n = 0, frame_tick = 0, slide_en = 0, buf_sel = 0;
  logic fb_rd_en, lcd_en_n, lcd_vsync_n, lcd_hsync_n, lcd_dclk;
  logic [AW-1:0] fb_rd_addr;
  logic [15:0] fb_rd_data, lcd_rgb;

  int n_chk = 0, n_bad = 0, gaps = 0;
  logic [17:0] sb[$];
  logic [17:0] exp_it;

  tft_frame_scanner #(.H_SYNC(HS), .H_PRE(HP), .H_ACT(HA), .H_POST(HQ),
    .V_SYNC(VS), .V_PRE(VP), .V_ACT(VA), .V_POST(VQ), .AW(AW),
    .BASE0(0), .BASE1(B1), .SLIDE_FRAMES(2)) i_tft_frame_scanner (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .slide_en(slide_en),
    .buf_sel(buf_sel), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
    .fb_rd_data(fb_rd_data), .lcd_en_n(lcd_en_n), .lcd_vsync_n(lcd_vsync_n),
    .lcd_hsync_n(lcd_hsync_n), .lcd_dclk(lcd_dclk), .lcd_rgb(lcd_rgb));

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input int a);
    return {a[14:0], 1'b1};
  endfunction

  always @(posedge clk)
    fb_rd_data <= fb_rd_en ? pat(int'(fb_rd_addr)) : 16'hDEAD;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(input bit b);
    for (int v = 0; v < VT; v++)
      for (int h = 0; h < HT; h++) begin
        bit act = v >= VS + VP && v < VS + VP + VA && h >= HS + HP && h < HS + HP + HA;
        int a = (b ? B1 : 0) + (v - VS - VP) * HA + (h - HS - HP);
        sb.push_back({h >= HS, v >= VS, act ? pat(a) : 16'h0000});
      end
  endtask

  task automatic tick();
    frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 600 && sb.size() != 0; i++) @(negedge clk);
    check("R4 frame completed", sb.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_en_n && !lcd_dclk) gaps++;
      if (lcd_dclk) begin
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 unexpected strobe actual=1 expected=0");
        end else begin
          exp_it = sb.pop_front();
          check("R4 hsync", lcd_hsync_n, exp_it[17]);
          check("R5 vsync", lcd_vsync_n, exp_it[16]);
          if (exp_it[15:0] == 0) check("R6 dummy pixel", lcd_rgb, 0);
          else check("R7 pixel data", lcd_rgb, exp_it[15:0]);
          check("R3 enable during strobe", lcd_en_n, 0);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 en_n", lcd_en_n, 1);
    check("R1 hsync", lcd_hsync_n, 1);
    check("R1 vsync", lcd_vsync_n, 1);
    check("R1 dclk", lcd_dclk, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R2 no frame without tick", lcd_en_n, 1);
    check("R1 rgb idle", lcd_rgb, 0);

    // R3 enable lead and trail
    gaps = 0;
    push_frame(0);
    tick();
    check("R3 enable low before strobe", lcd_en_n, 0);
    check("R3 no strobe in lead clock", lcd_dclk, 0);
    @(negedge clk);
    check("R3 first strobe", lcd_dclk, 1);
    drain();
    @(negedge clk);
    check("R3 enable high after frame", lcd_en_n, 1);
    check("R3 single lead clock", gaps, 1);

    // R8 buf_sel change mid-frame ignored
    push_frame(0);
    tick();
    repeat (10) @(negedge clk);
    buf_sel = 1;
    drain();
    repeat (2) @(negedge clk);
    push_frame(1);
    tick();
    drain();
    repeat (2) @(negedge clk);

    // R2 pending tick, collapse, back-to-back
    gaps = 0;
    push_frame(1);
    push_frame(1);
    tick();
    repeat (5) @(negedge clk);
    tick();
    repeat (5) @(negedge clk);
    tick();
    drain();
    repeat (60) @(negedge clk);
    check("R2 back-to-back no gap", gaps, 1);
    check("R2 ticks collapsed", sb.size(), 0);
    check("R2 idle after pending frame", lcd_en_n, 1);

    // R10 reset mid-frame
    push_frame(1);
    tick();
    repeat (20) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    sb.delete();
    check("R10 en_n in reset", lcd_en_n, 1);
    check("R10 dclk in reset", lcd_dclk, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", {lcd_en_n, lcd_hsync_n, lcd_vsync_n, lcd_dclk}, 4'b1110);

    // R9 slide show, buf_sel ignored
    slide_en = 1;
    buf_sel = 1;
    push_frame(0); tick(); drain(); repeat (2) @(negedge clk);
    push_frame(0); tick(); drain(); repeat (2) @(negedge clk);
    push_frame(1); tick(); drain(); repeat (2) @(negedge clk);
    push_frame(1); tick(); drain(); repeat (2) @(negedge clk);
    push_frame(0); tick(); drain(); repeat (5) @(negedge clk);
    check("R9 rotation done", lcd_en_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule